// File: doc/BRIEF.md
# Two-Stage Unlock ROM Bank Mapper

This block sits between a console's cartridge bus and a banked ROM. Each cycle it sees at most one bus access. It turns the access address into a physical ROM address made of a bank number and a 14-bit offset. The lower 16 KiB window (CPU 0x0000–0x3FFF) and the upper window (0x4000–0x7FFF) each get their own bank. Writes into the ROM region load three bank registers: base, mask and ROM bank.

After reset the mapper is locked, and it stays locked through two counted phases of ROM reads.

- **Stage A** is the first phase. Addresses pass through untouched apart from header descrambling.
- **Stage B** is the second phase. Address bit 7 of every lower-window read is forced high, so that the console sees a substitute logo.
- **Open** is the unlocked state. Bit 7 is no longer forced.

Any access to the cartridge RAM region during stage A skips ahead to stage B. The RAM region has no storage behind it: reads return all ones.

The named transitions are:

- **A_DONE**: stage A to stage B, on a ROM read with the counter full.
- **RAM_SKIP**: stage A to stage B, on any RAM-region access.
- **B_DONE**: stage B to open, on a ROM read with the counter full.
- **RESET**: any state to stage A.

No transition leads out of open except reset.

Top module: `lkmap_top`

## Requirements
- R1: After reset, `lock_state` reads 0 (stage A). The internal counter is 0, base is 0, mask is 0 and the ROM bank register is 1, so an upper-window read maps to bank 1 and a lower-window read maps to bank 0. The encoding of `lock_state` is 0 = stage A, 1 = stage B, 2 = open.
- R2: A ROM read is a cycle with `bus_req`=1, `bus_we`=0 and `bus_addr[15]`=0, and `rom_rd` is high exactly in such cycles. Each ROM read increments the counter. Once the counter reaches 48 it holds there.
- R3: A ROM read in stage A with the counter at 48 moves the mapper to stage B and clears the counter (A_DONE). That read is already served as a stage-B read. Stage A never goes directly to open.
- R4: A ROM read in stage B with the counter at 48 moves the mapper to open (B_DONE). That read is served as an open read. Open persists until reset.
- R5: In stage A, any read or write with `bus_req`=1 and `bus_addr[15:13]`=3'b101 (0xA000–0xBFFF) moves the mapper to stage B and clears the counter (RAM_SKIP). In stage B and in open, such accesses change nothing.
- R6: For lower-window ROM reads (`bus_addr[14]`=0), offset bit 7 is forced to 1 only when the read is served in stage B. In stage A and in open, bit 7 passes through unchanged.
- R7: For lower-window reads with `bus_addr[15:8]`=0x01, the offset bits are permuted as follows. Offset bit 0 takes address bit 6, offset bit 1 takes address bit 4, offset bit 4 takes address bit 1, and offset bit 6 takes address bit 0. The other bits are kept, apart from bit 7 under R6.
- R8: A ROM-region write with `bus_addr[14:13]`=01 loads the ROM bank register. A data value of 0 is stored as 1.
- R9: A ROM-region write with `bus_addr[14:13]`=00 loads base, and one with `bus_addr[14:13]`=10 loads mask. Both take effect only while ROM bank register bits 5:4 are both 1. Writes with `bus_addr[14:13]`=11 have no effect.
- R10: The lower bank is `base & mask`. The upper bank is `(base & mask) | (rombank & ~mask)`. The physical address is `{bank, offset[13:0]}`, and upper-window offsets pass through unchanged.
- R11: Reads of the RAM region return 0xFF on `ram_rdata`, and writes to it store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | Write data |
| rom_rd | output | 1 | Current cycle is a ROM read |
| rom_addr | output | 22 | Physical ROM address `{bank, offset}` |
| ram_rdata | output | 8 | RAM-region read data (always 0xFF) |
| lock_state | output | 2 | Lock state: 0 stage A, 1 stage B, 2 open |

## Verification
`rom_rd`, `rom_addr` and `ram_rdata` are combinational, so they answer the access presented in the same cycle. The bench drives each access at the falling edge and samples these outputs 1 ns later, before the next rising edge.

`lock_state` and the bank registers change at the rising edge that ends the access. Their effect is therefore due in the following cycle. The bench's reference model applies its own update only after it has compared that cycle's outputs, which keeps both sides on the same cycle.

The read that completes a phase is compared against the address mapping of the new state.

// File: rtl/lkmap_pkg.sv
package lkmap_pkg;

    typedef enum logic [1:0] {
        ST_STAGE_A = 2'd0,
        ST_STAGE_B = 2'd1,
        ST_OPEN    = 2'd2
    } lock_state_t;

    // Lower-window offset: optional logo bit force, then header bit permutation.
    function automatic logic [15:0] lower_offset(input logic [15:0] a, input logic force7);
        logic [15:0] o;
        o = a;
        if (force7) o[7] = 1'b1;
        if (a[15:8] == 8'h01) begin
            o[0] = a[6];
            o[1] = a[4];
            o[4] = a[1];
            o[6] = a[0];
        end
        return o;
    endfunction

endpackage

// File: rtl/lkmap_seq.sv
module lkmap_seq
    import lkmap_pkg::*;
#(
    parameter int PHASE_LEN = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rom_rd,
    input  logic        ram_acc,
    output lock_state_t state_q,
    output lock_state_t serve_state
);
    localparam int CNT_W = $clog2(PHASE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PHASE_LEN);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    lock_state_t      state_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_STAGE_A: begin
                if (ram_acc) begin
                    state_d = ST_STAGE_B;
                    cnt_d   = '0;
                end else if (rom_rd) begin
                    if (cnt_q == CNT_FULL) begin
                        state_d = ST_STAGE_B;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_STAGE_B: begin
                if (rom_rd) begin
                    if (cnt_q == CNT_FULL) state_d = ST_OPEN;
                    else                   cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_OPEN: begin
                if (rom_rd && cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
            end
            default: begin
                state_d = ST_STAGE_A;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STAGE_A;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb serve_state = rom_rd ? state_d : state_q;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL); // R2
    AST_A_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STAGE_A |=> state_q != ST_OPEN); // R3
    AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_OPEN |=> state_q == ST_OPEN); // R4
    AST_RAM_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAGE_A && ram_acc) |=> (state_q == ST_STAGE_B && cnt_q == '0)); // R5

endmodule

// File: rtl/lkmap_regs.sv
module lkmap_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] lo_bank,
    output logic [DATA_W-1:0] hi_bank
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] base_q, mask_q, rb_q;
    logic              cfg_open;

    always_comb cfg_open = rb_q[5] & rb_q[4];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            rb_q   <= ONE;
        end else if (wr_en) begin
            unique case (wr_sel)
                2'b00: if (cfg_open) base_q <= wr_data;
                2'b01: rb_q <= (wr_data == '0) ? ONE : wr_data;
                2'b10: if (cfg_open) mask_q <= wr_data;
                2'b11: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        lo_bank = base_q & mask_q;
        hi_bank = (base_q & mask_q) | (rb_q & ~mask_q);
    end

    AST_RB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rb_q != '0); // R8
    AST_BASE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b00 && !cfg_open) |=> $stable(base_q)); // R9
    AST_MASK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b10 && !cfg_open) |=> $stable(mask_q)); // R9

endmodule

// File: rtl/lkmap_addr.sv
module lkmap_addr
    import lkmap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [15:0]          cpu_addr,
    input  lock_state_t          serve_state,
    input  logic [DATA_W-1:0]    lo_bank,
    input  logic [DATA_W-1:0]    hi_bank,
    output logic [DATA_W+13:0]   phys
);
    logic [15:0] lo_off;

    always_comb begin
        lo_off = lower_offset(cpu_addr, serve_state == ST_STAGE_B);
        if (cpu_addr[14]) phys = {hi_bank, cpu_addr[13:0]};
        else              phys = {lo_bank, lo_off[13:0]};
    end

endmodule

// File: rtl/lkmap_top.sv
module lkmap_top
    import lkmap_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PHASE_LEN = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [15:0]          bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 rom_rd,
    output logic [DATA_W+13:0]   rom_addr,
    output logic [DATA_W-1:0]    ram_rdata,
    output logic [1:0]           lock_state
);
    lock_state_t       st_q, st_serve;
    logic              ram_acc, reg_wr;
    logic [DATA_W-1:0] lo_bank, hi_bank;

    always_comb begin
        rom_rd    = bus_req & ~bus_we & ~bus_addr[15];
        ram_acc   = bus_req & (bus_addr[15:13] == 3'b101);
        reg_wr    = bus_req & bus_we & ~bus_addr[15];
        ram_rdata = {DATA_W{1'b1}};
        lock_state = st_q;
    end

    lkmap_seq #(.PHASE_LEN(PHASE_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .rom_rd(rom_rd), .ram_acc(ram_acc),
        .state_q(st_q), .serve_state(st_serve)
    );

    lkmap_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(bus_addr[14:13]),
        .wr_data(bus_wdata), .lo_bank(lo_bank), .hi_bank(hi_bank)
    );

    lkmap_addr #(.DATA_W(DATA_W)) u_addr (
        .cpu_addr(bus_addr), .serve_state(st_serve),
        .lo_bank(lo_bank), .hi_bank(hi_bank), .phys(rom_addr)
    );

    AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && bus_addr[14]) |-> rom_addr[13:0] == bus_addr[13:0]); // R10
    AST_OPEN_NO_LOGO: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && !bus_addr[14] && bus_addr[15:8] != 8'h01 && st_q == ST_OPEN)
        |-> rom_addr[7] == bus_addr[7]); // R6

endmodule

// File: tb/tb_lkmap_top.sv
`timescale 1ns/1ps
module tb_lkmap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        rom_rd;
    logic [21:0] rom_addr;
    logic [7:0]  ram_rdata;
    logic [1:0]  lock_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_state, m_cnt, m_base, m_mask, m_rb;

    always #2.5 clk = ~clk;

    lkmap_top dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rom_rd(rom_rd),
        .rom_addr(rom_addr), .ram_rdata(ram_rdata), .lock_state(lock_state)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int model_addr(input int a, input int st);
        int off, bank;
        off = a;
        if ((a & 16'h4000) == 0) begin
            if (st == 1) off = off | 16'h0080;
            if ((a >> 8) == 1)
                off = (off & 16'hFFAC) | ((a >> 6) & 1) | (((a >> 4) & 1) << 1)
                      | (((a >> 1) & 1) << 4) | ((a & 1) << 6);
            bank = m_base & m_mask;
        end else begin
            bank = (m_base & m_mask) | (m_rb & ~m_mask & 8'hFF);
        end
        return bank * 16384 + (off & 16'h3FFF);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_state = 0; m_cnt = 0; m_base = 0; m_mask = 0; m_rb = 1;
        #1;
        check("R1 lock_state after reset", lock_state, 0);
    endtask

    task automatic access(input bit we, input int addr, input int data, input string tag);
        bit is_rom, is_ram;
        int ns, nc, serve;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = addr[15:0]; bus_wdata = data[7:0];
        #1;
        is_rom = !we && addr < 16'h8000;
        is_ram = addr >= 16'hA000 && addr < 16'hC000;
        ns = m_state; nc = m_cnt;
        if (m_state == 0 && is_ram) begin
            ns = 1; nc = 0;
        end else if (is_rom) begin
            if (m_cnt == 48) begin
                if (m_state == 0) begin ns = 1; nc = 0; end
                else if (m_state == 1) ns = 2;
            end else nc = m_cnt + 1;
        end
        serve = is_rom ? ns : m_state;
        check("R2 rom_rd", rom_rd, is_rom);
        check("R3 R4 R5 lock_state", lock_state, m_state);
        if (is_rom) check(tag, rom_addr, model_addr(addr, serve));
        if (is_ram && !we) check("R11 ram_rdata", ram_rdata, 8'hFF);
        if (we && addr < 16'h8000) begin
            case ((addr >> 13) & 3)
                0: if ((m_rb & 8'h30) == 8'h30) m_base = data;
                1: m_rb = (data == 0) ? 1 : data;
                2: if ((m_rb & 8'h30) == 8'h30) m_mask = data;
                default: ;
            endcase
        end
        m_state = ns; m_cnt = nc;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        #1;
        check("R2 idle rom_rd", rom_rd, 0);
        check("R1 idle lock_state", lock_state, m_state);
    endtask

    initial begin
        do_reset();
        // R1 reset banks, R6 no force in stage A, R7 descramble
        access(0, 16'h4123, 0, "R1 R10 upper bank 1 after reset");
        access(0, 16'h0012, 0, "R1 R6 lower stage A");
        access(0, 16'h0153, 0, "R7 header permutation stage A");
        access(0, 16'h01AA, 0, "R7 header permutation stage A");
        // R2 count through stage A, R3 transition
        for (int i = 0; i < 60; i++) access(0, (i * 777) & 16'h7FFF, 0, "R2 R3 counted read");
        check("R3 in stage B", lock_state, 1);
        access(0, 16'h0005, 0, "R6 bit7 forced stage B");
        access(0, 16'h0141, 0, "R6 R7 stage B header");
        access(0, 16'hA010, 0, "R5 ram read in stage B");
        access(1, 16'hB000, 8'h12, "R11 ram write");
        for (int i = 0; i < 50; i++) access(0, (i * 301) & 16'h3FFF, 0, "R4 counted read");
        check("R4 open", lock_state, 2);
        access(0, 16'h0005, 0, "R4 R6 open no force");
        idle();
        check("R4 open sticky", lock_state, 2);
        // R5 shortcut by write and by read
        do_reset();
        for (int i = 0; i < 10; i++) access(0, 16'h0080 + i, 0, "R2 pre-shortcut");
        access(1, 16'hA123, 8'h55, "R5 ram write shortcut");
        access(0, 16'h0022, 0, "R5 R6 after shortcut");
        do_reset();
        access(0, 16'hBFFF, 0, "R5 R11 ram read shortcut");
        idle();
        check("R5 stage B after ram read", lock_state, 1);
        // R8 R9 R10 register behaviour
        do_reset();
        access(1, 16'h2000, 8'h00, "R8 zero write");
        access(0, 16'h7FFF, 0, "R8 zero stored as one");
        access(1, 16'h0000, 8'h0F, "R9 base write blocked");
        access(1, 16'h4000, 8'hFF, "R9 mask write blocked");
        access(0, 16'h4001, 0, "R9 blocked writes no effect");
        access(1, 16'h3000, 8'h33, "R8 rombank 0x33");
        access(1, 16'h1000, 8'hA5, "R9 base write open");
        access(1, 16'h5000, 8'hF0, "R9 mask write open");
        access(0, 16'h0100, 0, "R10 lower bank");
        access(0, 16'h6ABC, 0, "R10 upper bank");
        access(1, 16'h6000, 8'hFF, "R9 0x6000 write ignored");
        access(1, 16'h7FFF, 8'h00, "R9 0x7FFF write ignored");
        access(0, 16'h4444, 0, "R9 R10 after ignored writes");
        access(1, 16'h2000, 8'h07, "R8 rombank 7");
        access(1, 16'h4000, 8'h00, "R9 mask blocked again");
        access(0, 16'h5555, 0, "R9 R10 mask kept");
        access(0, 16'h01FF, 0, "R7 R10 header top");
        idle();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule